// File: doc/BRIEF.md
# Pipelined Control Signal Carrier

This block moves the control word and register numbers that the decoder produces for each instruction down a five-stage pipeline. Each instruction's signals travel with it through three interstage buffers: decode-to-execute, execute-to-memory and memory-to-writeback. Every control bit therefore reaches the stage that consumes it in the same cycle as the instruction it belongs to.

Control bits are grouped by the stage that uses them. The execute group is an operand-source select, a two-bit ALU operation code and a destination-select bit. The memory group is read, write and branch. The writeback group is register-write and memory-to-register. Each buffer keeps only the groups that later stages still need. The execute group ends at the first buffer and the memory group ends at the second. The writeback group and the destination number go on to the last buffer.

The source numbers of the instruction in execute are exposed next to the destination numbers held in all three buffers, so that a forwarding unit can compare them. A single advance input moves all buffers together or holds all of them.

Top module: `pipe_ctrl_carrier`

## Requirements
- R1: While reset is high at a rising edge, every output of every buffer becomes zero on that edge. This includes all register-write and memory-write bits, so the pipeline starts full of bubbles.
- R2: On a rising edge with advance high and reset low, the execute-stage outputs take the values on the decode-stage inputs. This covers all control groups and the rs, rt and rd numbers.
- R3: On a rising edge with advance high and reset low, the memory-stage outputs (memory group, writeback group, rd) take the values the execute stage held before that edge.
- R4: On a rising edge with advance high and reset low, the writeback-stage outputs (writeback group, rd) take the values the memory stage held before that edge.
- R5: An instruction presented when advance is high appears at the writeback outputs after exactly three advancing edges, with its control bits unchanged.
- R6: On a rising edge with advance low and reset low, every output keeps its value. Decode inputs presented during such a cycle never appear at any output.
- R7: The destination numbers of three consecutive instructions are visible at the same time on the execute, memory and writeback rd outputs, each with its own value.
- R8: Reset takes priority over a held pipeline: reset with advance low still clears every buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance all buffers when high, hold when low |
| id_alu_src | input | 1 | Decode: ALU second operand from immediate |
| id_alu_op | input | 2 | Decode: ALU operation class |
| id_reg_dst | input | 1 | Decode: destination from rd field |
| id_mem_read | input | 1 | Decode: data memory read |
| id_mem_write | input | 1 | Decode: data memory write |
| id_branch | input | 1 | Decode: conditional branch |
| id_reg_write | input | 1 | Decode: register file write |
| id_mem_to_reg | input | 1 | Decode: write back load data |
| id_rs | input | REG_W | Decode: first source register number |
| id_rt | input | REG_W | Decode: second source register number |
| id_rd | input | REG_W | Decode: destination register number |
| ex_alu_src | output | 1 | Execute: operand source select |
| ex_alu_op | output | 2 | Execute: ALU operation class |
| ex_reg_dst | output | 1 | Execute: destination select |
| ex_mem_read | output | 1 | Execute: memory read bit in flight |
| ex_mem_write | output | 1 | Execute: memory write bit in flight |
| ex_branch | output | 1 | Execute: branch bit in flight |
| ex_reg_write | output | 1 | Execute: register write bit in flight |
| ex_mem_to_reg | output | 1 | Execute: memory-to-register bit in flight |
| ex_rs | output | REG_W | Execute: first source number |
| ex_rt | output | REG_W | Execute: second source number |
| ex_rd | output | REG_W | Execute: destination number |
| mem_mem_read | output | 1 | Memory: read enable |
| mem_mem_write | output | 1 | Memory: write enable |
| mem_branch | output | 1 | Memory: branch qualifier |
| mem_reg_write | output | 1 | Memory: register write bit in flight |
| mem_mem_to_reg | output | 1 | Memory: memory-to-register bit in flight |
| mem_rd | output | REG_W | Memory: destination number |
| wb_reg_write | output | 1 | Writeback: register file write enable |
| wb_mem_to_reg | output | 1 | Writeback: result select |
| wb_rd | output | REG_W | Writeback: destination number |

## Verification
The hardest situation to reach is a hold that falls in the middle of a stream of different instructions. The held contents must survive, and the decode values seen during the hold must never leak into any buffer. The bench issues a long stream of instructions whose control words and register numbers are arithmetic functions of their issue index. It drops advance on a fixed rhythm and drives unrelated values on the decode inputs while advance is low. A count of advances gives the issue index expected in each stage. The run ends with a reset applied while the pipeline is held.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int ALUOP_W = 2;

  typedef struct packed {
    logic               alu_src;
    logic [ALUOP_W-1:0] alu_op;
    logic               reg_dst;
  } ex_ctl_t;

  typedef struct packed {
    logic mem_read;
    logic mem_write;
    logic branch;
  } mem_ctl_t;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctl_t;

  localparam int EX_CTL_W  = $bits(ex_ctl_t);
  localparam int MEM_CTL_W = $bits(mem_ctl_t);
  localparam int WB_CTL_W  = $bits(wb_ctl_t);

endpackage

// File: rtl/pcc_stage_reg.sv
module pcc_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/pcc_idex_buf.sv
module pcc_idex_buf
  import pcc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  ex_ctl_t          ex_d,
  input  mem_ctl_t         mem_d,
  input  wb_ctl_t          wb_d,
  input  logic [REG_W-1:0] rs_d,
  input  logic [REG_W-1:0] rt_d,
  input  logic [REG_W-1:0] rd_d,
  output ex_ctl_t          ex_q,
  output mem_ctl_t         mem_q,
  output wb_ctl_t          wb_q,
  output logic [REG_W-1:0] rs_q,
  output logic [REG_W-1:0] rt_q,
  output logic [REG_W-1:0] rd_q
);

  localparam int W = EX_CTL_W + MEM_CTL_W + WB_CTL_W + 3 * REG_W;

  logic [W-1:0] d_vec, q_vec;

  assign d_vec = {ex_d, mem_d, wb_d, rs_d, rt_d, rd_d};
  assign {ex_q, mem_q, wb_q, rs_q, rt_q, rd_q} = q_vec;

  pcc_stage_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .en(en), .d(d_vec), .q(q_vec)
  );

endmodule

// File: rtl/pcc_exmem_buf.sv
module pcc_exmem_buf
  import pcc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  mem_ctl_t         mem_d,
  input  wb_ctl_t          wb_d,
  input  logic [REG_W-1:0] rd_d,
  output mem_ctl_t         mem_q,
  output wb_ctl_t          wb_q,
  output logic [REG_W-1:0] rd_q
);

  localparam int W = MEM_CTL_W + WB_CTL_W + REG_W;

  logic [W-1:0] d_vec, q_vec;

  assign d_vec = {mem_d, wb_d, rd_d};
  assign {mem_q, wb_q, rd_q} = q_vec;

  pcc_stage_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .en(en), .d(d_vec), .q(q_vec)
  );

endmodule

// File: rtl/pcc_memwb_buf.sv
module pcc_memwb_buf
  import pcc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  wb_ctl_t          wb_d,
  input  logic [REG_W-1:0] rd_d,
  output wb_ctl_t          wb_q,
  output logic [REG_W-1:0] rd_q
);

  localparam int W = WB_CTL_W + REG_W;

  logic [W-1:0] d_vec, q_vec;

  assign d_vec = {wb_d, rd_d};
  assign {wb_q, rd_q} = q_vec;

  pcc_stage_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .en(en), .d(d_vec), .q(q_vec)
  );

endmodule

// File: rtl/pipe_ctrl_carrier.sv
module pipe_ctrl_carrier
  import pcc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                id_alu_src,
  input  logic [ALUOP_W-1:0]  id_alu_op,
  input  logic                id_reg_dst,
  input  logic                id_mem_read,
  input  logic                id_mem_write,
  input  logic                id_branch,
  input  logic                id_reg_write,
  input  logic                id_mem_to_reg,
  input  logic [REG_W-1:0]    id_rs,
  input  logic [REG_W-1:0]    id_rt,
  input  logic [REG_W-1:0]    id_rd,
  output logic                ex_alu_src,
  output logic [ALUOP_W-1:0]  ex_alu_op,
  output logic                ex_reg_dst,
  output logic                ex_mem_read,
  output logic                ex_mem_write,
  output logic                ex_branch,
  output logic                ex_reg_write,
  output logic                ex_mem_to_reg,
  output logic [REG_W-1:0]    ex_rs,
  output logic [REG_W-1:0]    ex_rt,
  output logic [REG_W-1:0]    ex_rd,
  output logic                mem_mem_read,
  output logic                mem_mem_write,
  output logic                mem_branch,
  output logic                mem_reg_write,
  output logic                mem_mem_to_reg,
  output logic [REG_W-1:0]    mem_rd,
  output logic                wb_reg_write,
  output logic                wb_mem_to_reg,
  output logic [REG_W-1:0]    wb_rd
);

  // decode-side bundles
  ex_ctl_t  id_ex_c;
  mem_ctl_t id_mem_c;
  wb_ctl_t  id_wb_c;

  assign id_ex_c  = '{alu_src: id_alu_src, alu_op: id_alu_op, reg_dst: id_reg_dst};
  assign id_mem_c = '{mem_read: id_mem_read, mem_write: id_mem_write, branch: id_branch};
  assign id_wb_c  = '{reg_write: id_reg_write, mem_to_reg: id_mem_to_reg};

  // execute stage (ID/EX buffer)
  ex_ctl_t  s1_ex_c;
  mem_ctl_t s1_mem_c;
  wb_ctl_t  s1_wb_c;
  logic [REG_W-1:0] s1_rs, s1_rt, s1_rd;

  pcc_idex_buf #(.REG_W(REG_W)) u_idex (
    .clk(clk), .rst(rst), .en(adv),
    .ex_d(id_ex_c), .mem_d(id_mem_c), .wb_d(id_wb_c),
    .rs_d(id_rs), .rt_d(id_rt), .rd_d(id_rd),
    .ex_q(s1_ex_c), .mem_q(s1_mem_c), .wb_q(s1_wb_c),
    .rs_q(s1_rs), .rt_q(s1_rt), .rd_q(s1_rd)
  );

  // memory stage (EX/MEM buffer): execute group dropped
  mem_ctl_t s2_mem_c;
  wb_ctl_t  s2_wb_c;
  logic [REG_W-1:0] s2_rd;

  pcc_exmem_buf #(.REG_W(REG_W)) u_exmem (
    .clk(clk), .rst(rst), .en(adv),
    .mem_d(s1_mem_c), .wb_d(s1_wb_c), .rd_d(s1_rd),
    .mem_q(s2_mem_c), .wb_q(s2_wb_c), .rd_q(s2_rd)
  );

  // writeback stage (MEM/WB buffer): only writeback group and rd
  wb_ctl_t s3_wb_c;
  logic [REG_W-1:0] s3_rd;

  pcc_memwb_buf #(.REG_W(REG_W)) u_memwb (
    .clk(clk), .rst(rst), .en(adv),
    .wb_d(s2_wb_c), .rd_d(s2_rd),
    .wb_q(s3_wb_c), .rd_q(s3_rd)
  );

  assign ex_alu_src     = s1_ex_c.alu_src;
  assign ex_alu_op      = s1_ex_c.alu_op;
  assign ex_reg_dst     = s1_ex_c.reg_dst;
  assign ex_mem_read    = s1_mem_c.mem_read;
  assign ex_mem_write   = s1_mem_c.mem_write;
  assign ex_branch      = s1_mem_c.branch;
  assign ex_reg_write   = s1_wb_c.reg_write;
  assign ex_mem_to_reg  = s1_wb_c.mem_to_reg;
  assign ex_rs          = s1_rs;
  assign ex_rt          = s1_rt;
  assign ex_rd          = s1_rd;

  assign mem_mem_read   = s2_mem_c.mem_read;
  assign mem_mem_write  = s2_mem_c.mem_write;
  assign mem_branch     = s2_mem_c.branch;
  assign mem_reg_write  = s2_wb_c.reg_write;
  assign mem_mem_to_reg = s2_wb_c.mem_to_reg;
  assign mem_rd         = s2_rd;

  assign wb_reg_write   = s3_wb_c.reg_write;
  assign wb_mem_to_reg  = s3_wb_c.mem_to_reg;
  assign wb_rd          = s3_rd;

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                adv,
  input logic [8:0]          id_ctl,
  input logic [REG_W-1:0]    id_rs,
  input logic [REG_W-1:0]    id_rt,
  input logic [REG_W-1:0]    id_rd,
  input logic [8:0]          ex_ctl,
  input logic [REG_W-1:0]    ex_rs,
  input logic [REG_W-1:0]    ex_rt,
  input logic [REG_W-1:0]    ex_rd,
  input logic [4:0]          mem_ctl,
  input logic [REG_W-1:0]    mem_rd,
  input logic [1:0]          wb_ctl,
  input logic [REG_W-1:0]    wb_rd
);

  // R1: the cycle after reset is released, every buffer reads zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (ex_ctl == '0 && ex_rs == '0 && ex_rt == '0 && ex_rd == '0 &&
                    mem_ctl == '0 && mem_rd == '0 && wb_ctl == '0 && wb_rd == '0));

  assert_ex_capture_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> (ex_ctl == $past(id_ctl) && ex_rs == $past(id_rs) &&
             ex_rt == $past(id_rt) && ex_rd == $past(id_rd)));

  assert_mem_capture_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (mem_ctl == $past(ex_ctl[4:0]) && mem_rd == $past(ex_rd)));

  assert_wb_capture_R4: assert property (@(posedge clk) disable iff (rst)
    adv |=> (wb_ctl == $past(mem_ctl[1:0]) && wb_rd == $past(mem_rd)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(ex_ctl) && $stable(ex_rs) && $stable(ex_rt) && $stable(ex_rd) &&
              $stable(mem_ctl) && $stable(mem_rd) && $stable(wb_ctl) && $stable(wb_rd)));

endmodule

bind pipe_ctrl_carrier pcc_checker #(.REG_W(REG_W)) u_pcc_checker (
  .clk(clk), .rst(rst), .adv(adv),
  .id_ctl({id_alu_src, id_alu_op, id_reg_dst, id_mem_read, id_mem_write,
           id_branch, id_reg_write, id_mem_to_reg}),
  .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
  .ex_ctl({ex_alu_src, ex_alu_op, ex_reg_dst, ex_mem_read, ex_mem_write,
           ex_branch, ex_reg_write, ex_mem_to_reg}),
  .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
  .mem_ctl({mem_mem_read, mem_mem_write, mem_branch, mem_reg_write, mem_mem_to_reg}),
  .mem_rd(mem_rd),
  .wb_ctl({wb_reg_write, wb_mem_to_reg}),
  .wb_rd(wb_rd)
);

// File: tb/pipe_ctrl_carrier_bench.sv
module pipe_ctrl_carrier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;
  localparam int STEPS      = 700;
  localparam int STALL_OFS  = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;

  logic [8:0]       id_ctl = '0;
  logic [REG_W-1:0] id_rs = '0, id_rt = '0, id_rd = '0;

  logic             ex_alu_src, ex_reg_dst, ex_mem_read, ex_mem_write, ex_branch;
  logic             ex_reg_write, ex_mem_to_reg;
  logic [1:0]       ex_alu_op;
  logic [REG_W-1:0] ex_rs, ex_rt, ex_rd;
  logic             mem_mem_read, mem_mem_write, mem_branch, mem_reg_write, mem_mem_to_reg;
  logic [REG_W-1:0] mem_rd;
  logic             wb_reg_write, wb_mem_to_reg;
  logic [REG_W-1:0] wb_rd;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_ctrl_carrier #(.REG_W(REG_W)) u_pipe_ctrl_carrier (
    .clk(clk), .rst(rst), .adv(adv),
    .id_alu_src(id_ctl[8]), .id_alu_op(id_ctl[7:6]), .id_reg_dst(id_ctl[5]),
    .id_mem_read(id_ctl[4]), .id_mem_write(id_ctl[3]), .id_branch(id_ctl[2]),
    .id_reg_write(id_ctl[1]), .id_mem_to_reg(id_ctl[0]),
    .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
    .ex_alu_src(ex_alu_src), .ex_alu_op(ex_alu_op), .ex_reg_dst(ex_reg_dst),
    .ex_mem_read(ex_mem_read), .ex_mem_write(ex_mem_write), .ex_branch(ex_branch),
    .ex_reg_write(ex_reg_write), .ex_mem_to_reg(ex_mem_to_reg),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
    .mem_mem_read(mem_mem_read), .mem_mem_write(mem_mem_write), .mem_branch(mem_branch),
    .mem_reg_write(mem_reg_write), .mem_mem_to_reg(mem_mem_to_reg), .mem_rd(mem_rd),
    .wb_reg_write(wb_reg_write), .wb_mem_to_reg(wb_mem_to_reg), .wb_rd(wb_rd)
  );

  // instruction j as {ctl[8:0], rs, rt, rd}
  function automatic logic [23:0] instr(input int j);
    logic [8:0] c;
    logic [4:0] s, t, d;
    c = 9'((j * 37) + (j >> 4));
    s = 5'((j * 7) + 1);
    t = 5'((j * 11) + 3);
    d = 5'((j * 5) + 2);
    return {c, s, t, d};
  endfunction

  function automatic logic [23:0] ex_exp(input int j);
    return (j < 0) ? 24'd0 : instr(j);
  endfunction

  function automatic logic [9:0] mem_exp(input int j);
    logic [23:0] v;
    v = ex_exp(j);
    return {v[19:15], v[4:0]};
  endfunction

  function automatic logic [6:0] wb_exp(input int j);
    logic [23:0] v;
    v = ex_exp(j);
    return {v[16:15], v[4:0]};
  endfunction

  function automatic logic [23:0] ex_act();
    return {ex_alu_src, ex_alu_op, ex_reg_dst, ex_mem_read, ex_mem_write, ex_branch,
            ex_reg_write, ex_mem_to_reg, ex_rs, ex_rt, ex_rd};
  endfunction

  function automatic logic [9:0] mem_act();
    return {mem_mem_read, mem_mem_write, mem_branch, mem_reg_write, mem_mem_to_reg, mem_rd};
  endfunction

  function automatic logic [6:0] wb_act();
    return {wb_reg_write, wb_mem_to_reg, wb_rd};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int j);
    {id_ctl, id_rs, id_rt, id_rd} = instr(j);
  endtask

  // expected contents given k advances since reset
  task automatic check_pipe(input int k, input string tag);
    check({tag, " R2 execute"},   ex_act(),         ex_exp(k - 1));
    check({tag, " R3 memory"},    24'(mem_act()),   24'(mem_exp(k - 2)));
    check({tag, " R4/R5 wb"},     24'(wb_act()),    24'(wb_exp(k - 3)));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int adv_cnt;
    adv_cnt = 0;
    rst = 1'b1;
    adv = 1'b1;
    drive(5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset cleared all buffers despite advance being high
    check("R1 reset execute", ex_act(), 24'd0);
    check("R1 reset memory",  24'(mem_act()), 24'd0);
    check("R1 reset wb",      24'(wb_act()), 24'd0);
    rst = 1'b0;

    for (int s = 0; s < STEPS; s++) begin
      logic go;
      go = (s % 7 != 3) && (s % 13 != 9);
      adv = go;
      if (go) drive(adv_cnt);
      else    drive(adv_cnt + STALL_OFS + s);
      @(posedge clk);
      @(negedge clk);
      if (go) begin
        adv_cnt++;
        check_pipe(adv_cnt, "advance");
      end else begin
        check_pipe(adv_cnt, "R6 hold");
      end
      if (adv_cnt >= 3) begin
        checks++;
        if (ex_rd == mem_rd || mem_rd == wb_rd || ex_rd == wb_rd) begin
          errors++;
          $display("FAIL R7 rd ex=%0d mem=%0d wb=%0d expected three distinct", ex_rd, mem_rd, wb_rd);
        end
      end
    end

    // R8: reset while held
    adv = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset on hold execute", ex_act(), 24'd0);
    check("R8 reset on hold memory",  24'(mem_act()), 24'd0);
    check("R8 reset on hold wb",      24'(wb_act()), 24'd0);

    // one advance after reset: bubbles behind the new instruction
    adv = 1'b1;
    drive(42);
    @(posedge clk);
    @(negedge clk);
    check("R2 after reset execute", ex_act(), instr(42));
    check("R1 bubble memory", 24'(mem_act()), 24'd0);
    check("R1 bubble wb",     24'(wb_act()), 24'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule